// File: doc/BRIEF.md
# Multi-drop serial frame receiver

This block receives asynchronous serial frames on a single line and delivers them to a host through a small queue. The line is sampled sixteen times per bit and each bit is taken at its centre. A frame is one low start bit, eight data bits sent least-significant first, an optional ninth bit, and one stop bit. Frames that are kept go into a two-entry queue. Each entry holds the byte, the ninth bit and a flag for a bad stop bit. The host drains the queue through a valid/ready read port.

On a shared bus many receivers hear the same traffic, and the ninth bit marks frames that carry an address. With the address filter on in 9-bit mode, the receiver throws away every frame whose ninth bit is clear. The host therefore sees only address frames until it decides the frame was meant for it and turns the filter off. A frame that arrives while the queue is full raises a sticky overrun flag, and reception then pauses. Dropping the receive enable is the only way to clear the flag.

The read port follows valid/ready rules. `rd_valid_o` is high while the queue holds an entry, and the entry is popped on a clock edge where both `rd_valid_o` and `rd_ready_i` are high. While `rd_ready_i` stays low the head entry and `rd_valid_o` hold their values. Incoming data gets no back-pressure: a frame that finds no room is lost and reported as an overrun.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset `rd_valid_o`, `overrun_o` and `irq_o` are 0.
- R2: The sample interval is 4*(D+1) clocks when `rate_sel_i`=2'b00, D+1 clocks when 2'b01, and (D>>2)+1 clocks when `rate_sel_i[1]`=1, where D is `divisor_i`. One bit lasts 16 sample intervals.
- R3: A frame is a start bit (0), eight data bits LSB first, then a ninth bit only when `nine_bit_i`=1, then a stop bit. The bytes appear on `rd_data_o`. The ninth bit appears on `rd_bit9_o` and reads 0 for 8-bit frames.
- R4: Frames are received only while `port_en_i` and `rx_en_i` are both 1. When either is 0, line activity adds no entry.
- R5: A start needs a high-to-low change between two samples, and the line must still be low 8 samples later. A shorter low pulse is discarded and adds no entry.
- R6: With `addr_det_i`=1 and `nine_bit_i`=1, a frame whose ninth bit is 0 is dropped, and a frame whose ninth bit is 1 is queued. In 8-bit mode `addr_det_i` has no effect.
- R7: If the stop bit is sampled low, the entry is still queued, with `rd_ferr_o`=1 for that entry only.
- R8: The queue holds 2 entries in arrival order. A pop happens when `rd_valid_o` and `rd_ready_i` are both high. While `rd_ready_i` is low the head entry stays unchanged.
- R9: A frame that completes while the queue is full sets `overrun_o` and is lost. While `overrun_o`=1 no further frame is queued. Holding `rx_en_i` at 0 for one clock clears `overrun_o` and leaves the queued entries in place.
- R10: `irq_o` is 1 exactly when `irq_en_i`=1 and `rd_valid_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| port_en_i | input | 1 | Port enable |
| rx_en_i | input | 1 | Receive enable; low clears overrun |
| nine_bit_i | input | 1 | 1 selects 9-bit frames |
| addr_det_i | input | 1 | Address filter enable (9-bit mode) |
| rate_sel_i | input | 2 | Divide-ratio select, see R2 |
| divisor_i | input | 16 | Baud divisor D |
| irq_en_i | input | 1 | Interrupt enable |
| rd_ready_i | input | 1 | Host accepts the head entry |
| rd_valid_o | output | 1 | Queue holds an entry |
| rd_data_o | output | 8 | Head entry byte |
| rd_bit9_o | output | 1 | Head entry ninth bit |
| rd_ferr_o | output | 1 | Head entry stop-bit error |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Data-available interrupt |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. The overrun flag stays set and clears on a low receive enable. No entry is written while overrun is set or when the address filter should drop the frame. The head entry stays stable under back-pressure, and the interrupt only rises with data present. Other behaviour shows only when whole frames cross the line, so the bench scenarios cover it. This includes the bit order and centre sampling at each divide ratio and the rejection of short start pulses. It also includes how the filter, framing errors and overrun affect which frames reach the host.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  localparam int OSR_W  = $clog2(OSR);

  typedef struct packed {
    logic              ferr;
    logic              bit9;
    logic [DATA_W-1:0] data;
  } rx_frame_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_sel_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;

  // last count value of one sample interval
  always_comb begin
    if (rate_sel_i[1])
      limit = CNT_W'(divisor_i >> 2);
    else if (rate_sel_i[0])
      limit = CNT_W'(divisor_i);
    else
      limit = {divisor_i, 2'b11};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= limit) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic      run_i,
  input  logic      nine_bit_i,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [OSR_W-1:0] MID  = OSR_W'(OSR / 2 - 1);
  localparam logic [OSR_W-1:0] LAST = OSR_W'(OSR - 1);

  rx_state_e         state_q;
  logic [OSR_W-1:0]  smp_q;
  logic [BIT_W-1:0]  nbit_q;
  logic [DATA_W-1:0] shift_q;
  logic              b9_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      smp_q   <= '0;
      nbit_q  <= '0;
      shift_q <= '0;
      b9_q    <= 1'b0;
      last_q  <= 1'b1;
      done_o  <= 1'b0;
      frame_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) last_q <= rx_i;
      if (!run_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        smp_q <= smp_q + 1'b1;
        unique case (state_q)
          ST_IDLE: begin
            if (last_q && !rx_i) begin
              state_q <= ST_START;
              smp_q   <= '0;
            end
          end
          ST_START: begin
            if (smp_q == MID) begin
              smp_q  <= '0;
              nbit_q <= '0;
              state_q <= rx_i ? ST_IDLE : ST_DATA;
            end
          end
          ST_DATA: begin
            if (smp_q == LAST) begin
              shift_q <= {rx_i, shift_q[DATA_W-1:1]};
              nbit_q  <= nbit_q + 1'b1;
              if (nbit_q == BIT_W'(DATA_W - 1))
                state_q <= nine_bit_i ? ST_NINTH : ST_STOP;
            end
          end
          ST_NINTH: begin
            if (smp_q == LAST) begin
              b9_q    <= rx_i;
              state_q <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (smp_q == LAST) begin
              frame_o.ferr <= !rx_i;
              frame_o.bit9 <= nine_bit_i & b9_q;
              frame_o.data <= shift_q;
              done_o       <= 1'b1;
              state_q      <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push_i,
  input  rx_frame_t wdata_i,
  input  logic      pop_i,
  output rx_frame_t head_o,
  output logic      valid_o,
  output logic      full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  rx_frame_t       mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [CW-1:0]   cnt_q;
  logic            do_push, do_pop;

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;
  assign head_o  = mem_q[rd_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem_q[i] <= '0;
      else if (do_push && wr_q == AW'(i))    mem_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == TOP) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == TOP) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              port_en_i,
  input  logic              rx_en_i,
  input  logic              nine_bit_i,
  input  logic              addr_det_i,
  input  logic [1:0]        rate_sel_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              irq_en_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_bit9_o,
  output logic              rd_ferr_o,
  output logic              overrun_o
  ,output logic             irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic      tick, rx_s, run, done, keep, full_w, push_w, ovr_q;
  rx_frame_t frm, head;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sync_q[s] <= 1'b1;
      else if (s == 0) sync_q[s] <= rx_i;
      else         sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
    end
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  assign run = port_en_i && rx_en_i && !ovr_q;

  uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel_i),
    .divisor_i(divisor_i), .tick_o(tick)
  );

  uart_rx_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s), .run_i(run),
    .nine_bit_i(nine_bit_i), .done_o(done), .frame_o(frm)
  );

  assign keep   = !(addr_det_i && nine_bit_i && !frm.bit9);
  assign push_w = done && keep && !full_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovr_q <= 1'b0;
    else if (!rx_en_i)               ovr_q <= 1'b0;
    else if (done && keep && full_w) ovr_q <= 1'b1;
  end

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_w), .wdata_i(frm),
    .pop_i(rd_ready_i), .head_o(head), .valid_o(rd_valid_o), .full_o(full_w)
  );

  assign rd_data_o = head.data;
  assign rd_bit9_o = head.bit9;
  assign rd_ferr_o = head.ferr;
  assign overrun_o = ovr_q;
  assign irq_o     = irq_en_i && rd_valid_o;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en_i,
  input logic       nine_bit_i,
  input logic       addr_det_i,
  input logic       irq_en_i,
  input logic       rd_ready_i,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       rd_bit9_o,
  input logic       rd_ferr_o,
  input logic       overrun_o,
  input logic       irq_o,
  input logic       push,
  input logic       full,
  input logic       frame_bit9
);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o && rx_en_i |=> overrun_o);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !overrun_o);

  p_set_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(full));

  p_no_push_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> !push);

  p_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !(addr_det_i && nine_bit_i && !frame_bit9));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o &&
      $stable({rd_data_o, rd_bit9_o, rd_ferr_o}));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en_i && rd_valid_o);
endmodule

bind uart_addr_rx uart_addr_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .nine_bit_i(nine_bit_i),
  .addr_det_i(addr_det_i), .irq_en_i(irq_en_i), .rd_ready_i(rd_ready_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_bit9_o(rd_bit9_o),
  .rd_ferr_o(rd_ferr_o), .overrun_o(overrun_o), .irq_o(irq_o),
  .push(push_w), .full(full_w), .frame_bit9(frm.bit9)
);

// File: tb/uart_addr_rx_tb_top.sv
module uart_addr_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, port_en = 1'b1, rx_en = 1'b1, nine = 1'b0, addr = 1'b0;
  logic [1:0] rsel = 2'b01;
  logic [15:0] div = 16'd1;
  logic irq_en = 1'b1, rdy = 1'b0;
  logic rvalid, rbit9, rferr, ovr, irq;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  logic [9:0] q[$];
  logic ovr_m = 1'b0;

  always #2.5 clk = ~clk;

  uart_addr_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .port_en_i(port_en), .rx_en_i(rx_en),
    .nine_bit_i(nine), .addr_det_i(addr), .rate_sel_i(rsel), .divisor_i(div),
    .irq_en_i(irq_en), .rd_ready_i(rdy), .rd_valid_o(rvalid), .rd_data_o(rdata),
    .rd_bit9_o(rbit9), .rd_ferr_o(rferr), .overrun_o(ovr), .irq_o(irq)
  );

  function automatic int bit_len(input logic [1:0] s, input logic [15:0] d);
    if (s[1])      return 16 * (int'(d >> 2) + 1);
    else if (s[0]) return 16 * (int'(d) + 1);
    else           return 64 * (int'(d) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model(input logic [7:0] d, input logic b9, input logic ferr);
    if (!(port_en && rx_en) || ovr_m) return;
    if (addr && nine && !b9) return;
    if (q.size() >= 2) ovr_m = 1'b1;
    else q.push_back({ferr, nine & b9, d});
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic ferr);
    int bl = bit_len(rsel, div);
    rx = 1'b0; wait_clk(bl);
    for (int i = 0; i < 8; i++) begin rx = d[i]; wait_clk(bl); end
    if (nine) begin rx = b9; wait_clk(bl); end
    rx = !ferr; wait_clk(bl);
    rx = 1'b1; wait_clk(2 * bl);
    model(d, b9, ferr);
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) begin
      logic [9:0] e = q.pop_front();
      chk(rvalid == 1'b1, req, rvalid, 1);
      chk({rferr, rbit9, rdata} == e, req, {rferr, rbit9, rdata}, e);
      chk(irq == irq_en, "R10", irq, irq_en);
      rdy = 1'b1; wait_clk(1); rdy = 1'b0;
    end
    chk(rvalid == 1'b0, req, rvalid, 0);
    chk(irq == 1'b0, "R10", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    // R1: reset state
    chk(rvalid == 0 && ovr == 0 && irq == 0, "R1", {rvalid, ovr, irq}, 0);
    rst_n = 1'b1; wait_clk(20);

    // R3: 8-bit frames, R2 x16 ratio
    send(8'hA5, 1'b1, 1'b0); drain("R3");
    send(8'h3C, 1'b0, 1'b0);
    // R8: back-pressure, entry held
    wait_clk(50);
    chk(rvalid == 1 && rdata == 8'h3C, "R8", rdata, 8'h3C);
    send(8'h81, 1'b0, 1'b0); drain("R8");

    // R2: x64 and x4 ratios
    rsel = 2'b00; div = 16'd0; send(8'h5A, 1'b0, 1'b0); drain("R2");
    rsel = 2'b10; div = 16'd7; send(8'hC3, 1'b0, 1'b0); drain("R2");
    rsel = 2'b01; div = 16'd1;

    // R3: 9-bit frames
    nine = 1'b1; send(8'h12, 1'b1, 1'b0); send(8'h34, 1'b0, 1'b0); drain("R3");

    // R6: address filter
    addr = 1'b1;
    send(8'h55, 1'b0, 1'b0); drain("R6");
    send(8'h66, 1'b1, 1'b0); drain("R6");
    nine = 1'b0; send(8'h77, 1'b0, 1'b0); drain("R6");
    addr = 1'b0;

    // R7: framing error per entry
    send(8'h0F, 1'b0, 1'b1); send(8'hF0, 1'b0, 1'b0); drain("R7");

    // R5: short start pulse rejected
    rx = 1'b0; wait_clk(6); rx = 1'b1; wait_clk(bit_len(rsel, div) * 12);
    chk(rvalid == 1'b0, "R5", rvalid, 0);

    // R4: disabled port ignores traffic
    port_en = 1'b0; send(8'h99, 1'b0, 1'b0); drain("R4");
    port_en = 1'b1; rx_en = 1'b0; send(8'h98, 1'b0, 1'b0); drain("R4");
    rx_en = 1'b1;

    // R9: overrun
    send(8'h01, 1'b0, 1'b0); send(8'h02, 1'b0, 1'b0); send(8'h03, 1'b0, 1'b0);
    chk(ovr == 1'b1, "R9", ovr, 1);
    send(8'h04, 1'b0, 1'b0);
    chk(ovr == 1'b1, "R9", ovr, 1);
    rx_en = 1'b0; wait_clk(1); rx_en = 1'b1; ovr_m = 1'b0; wait_clk(1);
    chk(ovr == 1'b0, "R9", ovr, 0);
    drain("R9");
    send(8'h05, 1'b0, 1'b0); drain("R9");

    // R10: interrupt gated by enable
    irq_en = 1'b0; send(8'h44, 1'b0, 1'b0);
    chk(irq == 1'b0 && rvalid == 1'b1, "R10", {irq, rvalid}, 1);
    irq_en = 1'b1; wait_clk(1);
    chk(irq == 1'b1, "R10", irq, 1);
    drain("R10");

    // random mix, fixed seed
    void'($urandom(32'h5EED));
    for (int n = 0; n < 40; n++) begin
      int m = $urandom % 3;
      rsel = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
      div  = (m == 0) ? 16'd0 : (m == 1) ? 16'd2 : 16'd7;
      nine = 1'($urandom % 2);
      addr = 1'($urandom % 2);
      send(8'($urandom), 1'($urandom % 2), ($urandom % 10) == 0);
      if (q.size() == 2 || ($urandom % 2) == 1) drain("R3");
    end
    drain("R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule